// File: doc/BRIEF.md
# Machine-Mode Trap and Interrupt Unit

This block holds the machine-level trap state of a small 32-bit RISC-V style core. It owns the status, enable, pending, vector base, exception PC, cause, trap value and scratch registers. It takes three interrupt request lines (software, timer, external) and synchronous exception requests from the pipeline. It decides in the same cycle whether a trap is taken and where the fetch stage must jump.

The pipeline delivers each exception with its cause code, the faulting effective address and the raw instruction bits already computed. The unit stores whichever of the two the cause calls for. The core also reports the PC of the instruction at which a trap would be taken. The unit serves plain CSR reads and writes and the return-from-trap operation. It also reports the current privilege level, machine or user.

While reset is held, the unit steers fetch to a fixed reset vector. Exceptions, interrupts, returns and CSR writes then follow the precedence rules listed below.

Top module: `mtrap_unit`

## Requirements
- R1: While `rst` is high, `redirect_o` is 1 and `target_pc_o` equals `RESET_VEC`. After reset: privilege is machine (`priv_o`=3), status reads 0x0000_1800 (MIE=0, MPRV=0, MPP=3), cause reads `RESET_CAUSE`, and enable, vector base, exception PC, trap value and scratch all read 0.
- R2: An interrupt is taken only when status MIE (bit 3) is 1, its request line is high and its enable bit is set. The enable bits are bit 3 for software, bit 7 for timer and bit 11 for external. The pending CSR shows the live request lines at those same bit positions and ignores writes.
- R3: A synchronous exception beats every interrupt in the same cycle. Among enabled pending interrupts, external wins over software, and software wins over timer.
- R4: When vector-base bit 0 is 0 (direct mode), every trap jumps to the base, which is vector-base bits [31:2] with two zero bits appended.
- R5: When vector-base bit 0 is 1 (vectored mode), an interrupt jumps to base + 4 × its code. The codes are 3 for software, 7 for timer and 11 for external (offset 0x2C). Exceptions still jump to the base. Vector-base bit 1 always reads 0.
- R6: On trap entry, cause gets bit 31 = 1 for an interrupt and 0 for an exception, with the code in bits [4:0] and zeros elsewhere.
- R7: On trap entry, the trap value gets the faulting address for exception codes 0, 1, 3, 4, 5, 6, 7, 12, 13 and 15. It gets the instruction bits for code 2. It gets 0 for any other code and for every interrupt.
- R8: On trap entry, the exception PC gets `pc_i` and MPIE (bit 7) gets the old MIE. MIE is cleared, MPP (bits 12:11) gets the old privilege, and privilege becomes machine.
- R9: A return (`mret_i`) jumps to the exception PC. It sets MIE to MPIE, sets MPIE to 1, sets privilege to MPP and sets MPP to user (0). MPRV (bit 17) is cleared when the new privilege is user.
- R10: The scratch CSR is a plain 32-bit register that traps and returns never change.
- R11: In any one cycle, a trap wins over a return, and either one drops a CSR write in that cycle. Exception-PC bits [1:0] always read 0. A written MPP of 3 selects machine, and any other value selects user.
- R12: CSR numbers: status 0x300, enable 0x304, vector base 0x305, scratch 0x340, exception PC 0x341, cause 0x342, trap value 0x343, pending 0x344. Other numbers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_sw_i | input | 1 | Software interrupt request level |
| irq_tmr_i | input | 1 | Timer interrupt request level |
| irq_ext_i | input | 1 | External interrupt request level |
| exc_valid_i | input | 1 | Synchronous exception this cycle |
| exc_code_i | input | 5 | Exception cause code |
| exc_addr_i | input | 32 | Faulting effective address |
| exc_instr_i | input | 32 | Faulting instruction bits |
| pc_i | input | 32 | PC of the instruction at which a trap is taken |
| mret_i | input | 1 | Return-from-trap request |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 12 | CSR number for read and write |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data (combinational) |
| redirect_o | output | 1 | Fetch must jump this cycle |
| target_pc_o | output | 32 | Jump target when redirect_o is high |
| priv_o | output | 2 | Current privilege (3 machine, 0 user) |

## Verification
Randomized rounds pick the privilege, vector mode, base, enable mask, global enable and request lines. A third of the rounds also add an exception whose code comes from the address-fault, illegal-instruction and environment-call groups. These rounds tell the priority order and the gating by MIE and enable bits apart from plain line sensing. They also tell direct jumps from vectored ones, and address capture from instruction capture. Directed cases cover all three lines raised at once and the software-versus-timer tie. They also cover an exception that collides with a return and with a CSR write, and the read-back of the legal-value fields. Finally they cover returns to both privileges with MPRV set, which shows whether MPRV is cleared only on the way to user mode.

// File: rtl/mtrap_pkg.sv
`timescale 1ns/1ps
package mtrap_pkg;
    localparam int XLEN   = 32;
    localparam int CODE_W = 5;

    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_M = 2'b11
    } priv_e;

    localparam logic [11:0] CSR_STATUS  = 12'h300;
    localparam logic [11:0] CSR_IE      = 12'h304;
    localparam logic [11:0] CSR_VBASE   = 12'h305;
    localparam logic [11:0] CSR_SCRATCH = 12'h340;
    localparam logic [11:0] CSR_EPC     = 12'h341;
    localparam logic [11:0] CSR_CAUSE   = 12'h342;
    localparam logic [11:0] CSR_TVAL    = 12'h343;
    localparam logic [11:0] CSR_IP      = 12'h344;

    localparam logic [CODE_W-1:0] CODE_SW      = 5'd3;
    localparam logic [CODE_W-1:0] CODE_TMR     = 5'd7;
    localparam logic [CODE_W-1:0] CODE_EXT     = 5'd11;
    localparam logic [CODE_W-1:0] CODE_ILLEGAL = 5'd2;

    typedef struct packed {
        logic  mprv;
        priv_e mpp;
        logic  mpie;
        logic  mie;
    } status_t;

    typedef struct packed {
        logic ext;
        logic tmr;
        logic sw;
    } irq_vec_t;

    typedef struct packed {
        logic              valid;
        logic              is_irq;
        logic [CODE_W-1:0] code;
    } trap_sel_t;

    function automatic logic [XLEN-1:0] status_word(status_t s);
        logic [XLEN-1:0] w;
        w         = '0;
        w[17]     = s.mprv;
        w[12:11]  = s.mpp;
        w[7]      = s.mpie;
        w[3]      = s.mie;
        return w;
    endfunction

    function automatic logic [XLEN-1:0] irq_word(irq_vec_t v);
        logic [XLEN-1:0] w;
        w     = '0;
        w[11] = v.ext;
        w[7]  = v.tmr;
        w[3]  = v.sw;
        return w;
    endfunction

    function automatic logic code_is_addr(logic [CODE_W-1:0] c);
        case (c)
            5'd0, 5'd1, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7,
            5'd12, 5'd13, 5'd15: return 1'b1;
            default:             return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/mtrap_irq_arb.sv
`timescale 1ns/1ps
module mtrap_irq_arb
    import mtrap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  irq_vec_t  pend_i,
    input  irq_vec_t  en_i,
    input  logic      glb_en_i,
    output trap_sel_t sel_o
);
    logic [2:0] act;

    always_comb begin
        act   = pend_i & en_i;
        sel_o = '0;
        if (glb_en_i) begin
            if (act[2]) begin
                sel_o.valid  = 1'b1;
                sel_o.is_irq = 1'b1;
                sel_o.code   = CODE_EXT;
            end else if (act[0]) begin
                sel_o.valid  = 1'b1;
                sel_o.is_irq = 1'b1;
                sel_o.code   = CODE_SW;
            end else if (act[1]) begin
                sel_o.valid  = 1'b1;
                sel_o.is_irq = 1'b1;
                sel_o.code   = CODE_TMR;
            end
        end
    end

    // R2: no interrupt selected without the global enable
    assert_irq_gate_R2: assert property (@(posedge clk) disable iff (rst)
        sel_o.valid |-> glb_en_i);

    // R3: an enabled external request always wins
    assert_ext_first_R3: assert property (@(posedge clk) disable iff (rst)
        (glb_en_i && pend_i.ext && en_i.ext) |-> (sel_o.valid && sel_o.code == CODE_EXT));

    // R3: timer only when nothing higher is enabled and pending
    assert_tmr_last_R3: assert property (@(posedge clk) disable iff (rst)
        (sel_o.valid && sel_o.code == CODE_TMR) |->
            !(pend_i.sw && en_i.sw) && !(pend_i.ext && en_i.ext));
endmodule

// File: rtl/mtrap_target.sv
`timescale 1ns/1ps
module mtrap_target
    import mtrap_pkg::*;
#(
    parameter bit VECTORED = 1'b1
) (
    input  logic [XLEN-3:0] base_i,
    input  logic            vec_mode_i,
    input  trap_sel_t       sel_i,
    output logic [XLEN-1:0] tgt_o
);
    localparam int PAD_W = XLEN - CODE_W - 2;

    logic [XLEN-1:0] base_addr;
    assign base_addr = {base_i, 2'b00};

    generate
        if (VECTORED) begin : g_vec
            logic [XLEN-1:0] offset;
            assign offset = {{PAD_W{1'b0}}, sel_i.code, 2'b00};
            assign tgt_o  = (vec_mode_i && sel_i.valid && sel_i.is_irq)
                            ? base_addr + offset : base_addr;
        end else begin : g_direct
            logic unused_sel;
            assign unused_sel = vec_mode_i ^ (^sel_i);
            assign tgt_o      = base_addr;
        end
    endgenerate
endmodule

// File: rtl/mtrap_unit.sv
`timescale 1ns/1ps
module mtrap_unit
    import mtrap_pkg::*;
#(
    parameter logic [31:0] RESET_VEC   = 32'h0000_1000,
    parameter logic [31:0] RESET_CAUSE = 32'h0000_0000,
    parameter bit          VECTORED    = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        irq_sw_i,
    input  logic        irq_tmr_i,
    input  logic        irq_ext_i,
    input  logic        exc_valid_i,
    input  logic [4:0]  exc_code_i,
    input  logic [31:0] exc_addr_i,
    input  logic [31:0] exc_instr_i,
    input  logic [31:0] pc_i,
    input  logic        mret_i,
    input  logic        csr_we_i,
    input  logic [11:0] csr_addr_i,
    input  logic [31:0] csr_wdata_i,
    output logic [31:0] csr_rdata_o,
    output logic        redirect_o,
    output logic [31:0] target_pc_o,
    output logic [1:0]  priv_o
);
    localparam int ZPAD = XLEN - 1 - CODE_W;

    status_t         st_q;
    priv_e           priv_q;
    irq_vec_t        ie_q;
    irq_vec_t        ip;
    logic [XLEN-3:0] vbase_q;
    logic            vmode_q;
    logic [XLEN-1:0] epc_q;
    logic [XLEN-1:0] cause_q;
    logic [XLEN-1:0] tval_q;
    logic [XLEN-1:0] scratch_q;

    trap_sel_t       irq_sel;
    trap_sel_t       cur_sel;
    logic [XLEN-1:0] trap_tgt;
    logic            exc_take, irq_take, trap_take, mret_take, csr_wr_ok;
    logic [XLEN-1:0] tval_next;

    assign ip = '{ext: irq_ext_i, tmr: irq_tmr_i, sw: irq_sw_i};

    mtrap_irq_arb u_arb (
        .clk      (clk),
        .rst      (rst),
        .pend_i   (ip),
        .en_i     (ie_q),
        .glb_en_i (st_q.mie),
        .sel_o    (irq_sel)
    );

    assign exc_take  = exc_valid_i;
    assign irq_take  = !exc_take && irq_sel.valid;
    assign trap_take = exc_take || irq_take;
    assign mret_take = mret_i && !trap_take;
    assign csr_wr_ok = csr_we_i && !trap_take && !mret_take;

    always_comb begin
        if (exc_take) begin
            cur_sel.valid  = 1'b1;
            cur_sel.is_irq = 1'b0;
            cur_sel.code   = exc_code_i;
        end else begin
            cur_sel = irq_sel;
        end
    end

    mtrap_target #(.VECTORED(VECTORED)) u_tgt (
        .base_i     (vbase_q),
        .vec_mode_i (vmode_q),
        .sel_i      (cur_sel),
        .tgt_o      (trap_tgt)
    );

    always_comb begin
        if (cur_sel.is_irq)                  tval_next = '0;
        else if (code_is_addr(cur_sel.code)) tval_next = exc_addr_i;
        else if (cur_sel.code == CODE_ILLEGAL) tval_next = exc_instr_i;
        else                                 tval_next = '0;
    end

    assign redirect_o  = rst || trap_take || mret_take;
    assign target_pc_o = rst ? RESET_VEC : (trap_take ? trap_tgt : epc_q);
    assign priv_o      = priv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '{mprv: 1'b0, mpp: PRIV_M, mpie: 1'b0, mie: 1'b0};
            priv_q    <= PRIV_M;
            ie_q      <= '0;
            vbase_q   <= '0;
            vmode_q   <= 1'b0;
            epc_q     <= '0;
            cause_q   <= RESET_CAUSE;
            tval_q    <= '0;
            scratch_q <= '0;
        end else if (trap_take) begin
            epc_q     <= {pc_i[XLEN-1:2], 2'b00};
            cause_q   <= {cur_sel.is_irq, {ZPAD{1'b0}}, cur_sel.code};
            tval_q    <= tval_next;
            st_q.mpie <= st_q.mie;
            st_q.mie  <= 1'b0;
            st_q.mpp  <= priv_q;
            priv_q    <= PRIV_M;
        end else if (mret_take) begin
            st_q.mie  <= st_q.mpie;
            st_q.mpie <= 1'b1;
            st_q.mpp  <= PRIV_U;
            priv_q    <= st_q.mpp;
            if (st_q.mpp != PRIV_M) st_q.mprv <= 1'b0;
        end else if (csr_wr_ok) begin
            case (csr_addr_i)
                CSR_STATUS: begin
                    st_q.mprv <= csr_wdata_i[17];
                    st_q.mpp  <= (csr_wdata_i[12:11] == 2'b11) ? PRIV_M : PRIV_U;
                    st_q.mpie <= csr_wdata_i[7];
                    st_q.mie  <= csr_wdata_i[3];
                end
                CSR_IE: begin
                    ie_q.ext <= csr_wdata_i[11];
                    ie_q.tmr <= csr_wdata_i[7];
                    ie_q.sw  <= csr_wdata_i[3];
                end
                CSR_VBASE: begin
                    vbase_q <= csr_wdata_i[XLEN-1:2];
                    vmode_q <= VECTORED ? csr_wdata_i[0] : 1'b0;
                end
                CSR_SCRATCH: scratch_q <= csr_wdata_i;
                CSR_EPC:     epc_q     <= {csr_wdata_i[XLEN-1:2], 2'b00};
                CSR_CAUSE:   cause_q   <= csr_wdata_i;
                CSR_TVAL:    tval_q    <= csr_wdata_i;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (csr_addr_i)
            CSR_STATUS:  csr_rdata_o = status_word(st_q);
            CSR_IE:      csr_rdata_o = irq_word(ie_q);
            CSR_IP:      csr_rdata_o = irq_word(ip);
            CSR_VBASE:   csr_rdata_o = {vbase_q, 1'b0, vmode_q};
            CSR_SCRATCH: csr_rdata_o = scratch_q;
            CSR_EPC:     csr_rdata_o = epc_q;
            CSR_CAUSE:   csr_rdata_o = cause_q;
            CSR_TVAL:    csr_rdata_o = tval_q;
            default:     csr_rdata_o = '0;
        endcase
    end

    // R8: trap entry clears MIE and lands in machine mode
    assert_entry_mie_off_R8: assert property (@(posedge clk) disable iff (rst)
        trap_take |=> (!st_q.mie && priv_q == PRIV_M));

    // R8: previous MIE saved into MPIE
    assert_entry_mpie_R8: assert property (@(posedge clk) disable iff (rst)
        trap_take |=> (st_q.mpie == $past(st_q.mie)));

    // R9: return restores MIE from MPIE and sets MPIE
    assert_mret_restore_R9: assert property (@(posedge clk) disable iff (rst)
        (mret_i && !exc_valid_i && !irq_sel.valid) |=>
            (st_q.mie == $past(st_q.mpie) && st_q.mpie && st_q.mpp == PRIV_U));

    // R10: scratch moves only through its own CSR write
    assert_scratch_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !(csr_we_i && csr_addr_i == CSR_SCRATCH) |=> $stable(scratch_q));

    // R6: an exception never records the interrupt flag
    assert_exc_cause_R6: assert property (@(posedge clk) disable iff (rst)
        exc_valid_i |=> !cause_q[XLEN-1]);

    // R11: a colliding CSR write leaves the scratch register unchanged
    assert_write_dropped_R11: assert property (@(posedge clk) disable iff (rst)
        (csr_we_i && (exc_valid_i || mret_i)) |=> $stable(scratch_q));
endmodule

// File: tb/sim_mtrap_unit.sv
`timescale 1ns/1ps
module sim_mtrap_unit;
    localparam logic [31:0] RV  = 32'h0000_1000;
    localparam logic [31:0] RC  = 32'h0000_0000;
    localparam logic [11:0] A_ST = 12'h300, A_IE = 12'h304, A_VB = 12'h305,
                            A_SC = 12'h340, A_EPC = 12'h341, A_CA = 12'h342,
                            A_TV = 12'h343, A_IP = 12'h344;

    logic        clk = 1'b0;
    logic        rst;
    logic        irq_sw_i, irq_tmr_i, irq_ext_i;
    logic        exc_valid_i;
    logic [4:0]  exc_code_i;
    logic [31:0] exc_addr_i, exc_instr_i, pc_i;
    logic        mret_i, csr_we_i;
    logic [11:0] csr_addr_i;
    logic [31:0] csr_wdata_i, csr_rdata_o, target_pc_o;
    logic        redirect_o;
    logic [1:0]  priv_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    mtrap_unit #(.RESET_VEC(RV), .RESET_CAUSE(RC)) u0 (
        .clk(clk), .rst(rst),
        .irq_sw_i(irq_sw_i), .irq_tmr_i(irq_tmr_i), .irq_ext_i(irq_ext_i),
        .exc_valid_i(exc_valid_i), .exc_code_i(exc_code_i),
        .exc_addr_i(exc_addr_i), .exc_instr_i(exc_instr_i), .pc_i(pc_i),
        .mret_i(mret_i), .csr_we_i(csr_we_i), .csr_addr_i(csr_addr_i),
        .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o),
        .redirect_o(redirect_o), .target_pc_o(target_pc_o), .priv_o(priv_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        csr_we_i = 1'b1; csr_addr_i = a; csr_wdata_i = d;
        step();
        csr_we_i = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        csr_addr_i = a;
        #1;
        d = csr_rdata_o;
    endtask

    task automatic rdchk(input string tag, input logic [11:0] a, input logic [31:0] e);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, e);
    endtask

    task automatic do_mret();
        mret_i = 1'b1;
        step();
        mret_i = 1'b0;
    endtask

    function automatic logic [31:0] st_val(bit mprv, logic [1:0] mpp, bit mpie, bit mie);
        return ({31'd0, mprv} << 17) | ({30'd0, mpp} << 11) | ({31'd0, mpie} << 7) | ({31'd0, mie} << 3);
    endfunction

    function automatic logic [31:0] ie_val(logic [2:0] e);
        return ({31'd0, e[2]} << 11) | ({31'd0, e[1]} << 7) | ({31'd0, e[0]} << 3);
    endfunction

    function automatic logic [5:0] pick_irq(logic [2:0] lines, logic [2:0] en, bit gmie);
        logic [2:0] a;
        a = lines & en;
        if (!gmie)     return 6'd0;
        if (a[2])      return {1'b1, 5'd11};
        if (a[0])      return {1'b1, 5'd3};
        if (a[1])      return {1'b1, 5'd7};
        return 6'd0;
    endfunction

    function automatic logic [31:0] exp_tval(logic [4:0] c, logic [31:0] ad, logic [31:0] ins);
        case (c)
            5'd0, 5'd1, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd12, 5'd13, 5'd15: return ad;
            5'd2: return ins;
            default: return 32'd0;
        endcase
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int codes[13] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 11, 12, 13, 15};
        void'($urandom(32'd4242));
        rst = 1'b1;
        {irq_sw_i, irq_tmr_i, irq_ext_i, exc_valid_i, mret_i, csr_we_i} = '0;
        exc_code_i = '0; exc_addr_i = '0; exc_instr_i = '0; pc_i = '0;
        csr_addr_i = '0; csr_wdata_i = '0;
        step(); step();
        #1;
        chk("R1 redirect in reset", {31'd0, redirect_o}, 32'd1);
        chk("R1 reset vector", target_pc_o, RV);
        step();
        rst = 1'b0;
        #1;
        chk("R1 no redirect after reset", {31'd0, redirect_o}, 32'd0);
        chk("R1 priv", {30'd0, priv_o}, 32'd3);
        rdchk("R1 status", A_ST, 32'h0000_1800);
        rdchk("R1 cause", A_CA, RC);
        rdchk("R1 enable", A_IE, 0);
        rdchk("R1 vbase", A_VB, 0);
        rdchk("R1 epc", A_EPC, 0);
        rdchk("R1 tval", A_TV, 0);
        rdchk("R1 scratch", A_SC, 0);
        step();

        // directed: all three lines, vectored
        wr(A_SC, 32'hCAFE_F00D);
        wr(A_VB, 32'h8000_0101);
        wr(A_IE, 32'h888);
        wr(A_ST, 32'h0000_1808);
        irq_sw_i = 1; irq_tmr_i = 1; irq_ext_i = 1; pc_i = 32'h2000;
        #1;
        chk("R3 R5 ext wins vectored", target_pc_o, 32'h8000_012C);
        chk("R2 redirect", {31'd0, redirect_o}, 32'd1);
        step();
        irq_sw_i = 0; irq_tmr_i = 0; irq_ext_i = 0;
        rdchk("R6 ext cause", A_CA, 32'h8000_000B);
        rdchk("R8 epc", A_EPC, 32'h2000);
        rdchk("R7 irq tval zero", A_TV, 0);
        rdchk("R8 status entry", A_ST, 32'h0000_1880);
        rdchk("R10 scratch kept", A_SC, 32'hCAFE_F00D);
        mret_i = 1;
        #1;
        chk("R9 return target", target_pc_o, 32'h2000);
        step();
        mret_i = 0;
        rdchk("R9 status after return", A_ST, 32'h0000_0088);
        chk("R9 priv", {30'd0, priv_o}, 32'd3);
        rdchk("R10 scratch after return", A_SC, 32'hCAFE_F00D);

        // software beats timer
        irq_sw_i = 1; irq_tmr_i = 1; pc_i = 32'h3000;
        #1;
        chk("R3 sw over timer", target_pc_o, 32'h8000_010C);
        step();
        irq_sw_i = 0; irq_tmr_i = 0;
        rdchk("R6 sw cause", A_CA, 32'h8000_0003);
        do_mret();

        // exception collides with ext line, return and CSR write
        irq_ext_i = 1; exc_valid_i = 1; exc_code_i = 5'd2;
        exc_instr_i = 32'hDEAD_BEEF; exc_addr_i = 32'h1111_2222; pc_i = 32'h4004;
        mret_i = 1; csr_we_i = 1; csr_addr_i = A_SC; csr_wdata_i = 32'h1234;
        #1;
        chk("R3 R5 exc to base", target_pc_o, 32'h8000_0100);
        step();
        irq_ext_i = 0; exc_valid_i = 0; mret_i = 0; csr_we_i = 0;
        rdchk("R6 exc cause", A_CA, 32'h2);
        rdchk("R7 illegal tval", A_TV, 32'hDEAD_BEEF);
        rdchk("R11 write dropped", A_SC, 32'hCAFE_F00D);
        rdchk("R11 return dropped epc", A_EPC, 32'h4004);
        chk("R11 priv after trap", {30'd0, priv_o}, 32'd3);

        // field legality
        wr(A_VB, 32'h4000_0003);
        rdchk("R5 mode bit1 reads 0", A_VB, 32'h4000_0001);
        wr(A_VB, 32'h4000_0002);
        rdchk("R4 mode 2 reads direct", A_VB, 32'h4000_0000);
        wr(A_EPC, 32'h0000_1003);
        rdchk("R11 epc align", A_EPC, 32'h0000_1000);
        wr(A_ST, 32'h0000_0800);
        rdchk("R11 mpp illegal to U", A_ST, 32'h0);
        irq_sw_i = 1; irq_tmr_i = 1;
        rdchk("R2 pending lines", A_IP, 32'h88);
        wr(A_IP, 32'h0);
        rdchk("R2 pending ignores write", A_IP, 32'h88);
        chk("R2 no trap with MIE off", {31'd0, redirect_o}, 32'd0);
        irq_sw_i = 0; irq_tmr_i = 0;
        rdchk("R12 unknown csr", 12'h7C0, 0);

        // MPRV on return
        wr(A_ST, 32'h0002_0000);
        do_mret();
        rdchk("R9 mprv cleared to U", A_ST, 32'h0000_0080);
        chk("R9 priv U", {30'd0, priv_o}, 32'd0);
        wr(A_ST, 32'h0002_1800);
        do_mret();
        rdchk("R9 mprv kept to M", A_ST, 32'h0002_0080);
        chk("R9 priv M", {30'd0, priv_o}, 32'd3);

        // randomized rounds
        for (int it = 0; it < 250; it++) begin
            logic [1:0]  p;
            logic [31:0] base, pcv, ad, ins, stw, e_tgt;
            bit          mode, gmie, mpie, mprv, ex;
            logic [2:0]  en, lines;
            logic [4:0]  code;
            logic [5:0]  ir;
            p = ($urandom % 2) ? 2'b11 : 2'b00;
            wr(A_ST, st_val(0, p, 0, 0));
            wr(A_EPC, 32'h100);
            do_mret();
            base = $urandom & 32'hFFFF_FF00;
            mode = $urandom % 2;
            en   = $urandom % 8;
            gmie = $urandom % 2;
            mpie = $urandom % 2;
            mprv = $urandom % 2;
            wr(A_VB, base | {31'd0, mode});
            wr(A_IE, ie_val(en));
            stw = st_val(mprv, p, mpie, gmie);
            wr(A_ST, stw);
            lines = $urandom % 8;
            ex    = ($urandom % 3) == 0;
            code  = 5'(codes[$urandom % 13]);
            ad    = $urandom;
            ins   = $urandom;
            pcv   = $urandom & 32'hFFFF_FFFC;
            ir    = pick_irq(lines, en, gmie);
            irq_sw_i = lines[0]; irq_tmr_i = lines[1]; irq_ext_i = lines[2];
            exc_valid_i = ex; exc_code_i = code; exc_addr_i = ad;
            exc_instr_i = ins; pc_i = pcv;
            #1;
            if (ex) begin
                chk("R3 R4 R5 exc redirect", {31'd0, redirect_o}, 32'd1);
                chk("R4 R5 exc target", target_pc_o, base);
            end else if (ir[5]) begin
                e_tgt = mode ? base + {25'd0, ir[4:0], 2'b00} : base;
                chk("R2 irq redirect", {31'd0, redirect_o}, 32'd1);
                chk("R3 R4 R5 irq target", target_pc_o, e_tgt);
            end else begin
                chk("R2 gated no redirect", {31'd0, redirect_o}, 32'd0);
            end
            step();
            {irq_sw_i, irq_tmr_i, irq_ext_i, exc_valid_i} = '0;
            if (ex || ir[5]) begin
                rdchk("R6 cause", A_CA, ex ? {27'd0, code} : {1'b1, 26'd0, ir[4:0]});
                rdchk("R8 epc", A_EPC, pcv);
                rdchk("R7 tval", A_TV, ex ? exp_tval(code, ad, ins) : 32'd0);
                rdchk("R8 status", A_ST, st_val(mprv, p, gmie, 0));
                chk("R8 priv M", {30'd0, priv_o}, 32'd3);
            end else begin
                rdchk("R2 status unchanged", A_ST, stw);
                chk("R2 priv unchanged", {30'd0, priv_o}, {30'd0, p});
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule